// File: doc/BRIEF.md
# Per-Module Test Plan Controller

This block is a non-scan test controller that takes over the control signals of a register-transfer data path while one combinational module at a time is being tested. A test plan is a short, fixed sequence of control settings. For each time step it says which control lines are forced, to what constant, and which line instead carries a bit of the current test pattern. The controller holds the index of the module under test and the free pattern bit in two small registers. A load strobe fills both registers from primary inputs. In the cycles after that, a sequencer steps through the selected plan one time step per clock. A decoder turns the step into a drive mask and a value for each control line.

Applying one pattern to a module therefore takes one load cycle followed by one cycle per plan step. Test software on the primary inputs issues the next load in the cycle in which the done pulse appears. A mode input selects between test and normal operation. In normal mode the controller is quiet and the data path's own controller keeps the lines. All pins are plain control and status: nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `test_plan_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first load, `ctl_drv`, `ctl_val` and `plan_done` are all 0.
- R2: With `test_mode`=1, a clock edge with `load`=1 captures `pi_mod` and `pi_pat` and starts the plan at step 0. This also applies in the middle of a running plan, which restarts with the new values. At any other edge both registers keep their values.
- R3: A plan's first step is presented in the cycle after the load edge, and each further edge advances one step. The plans for module index 0, 1, 2 and 3 last 3, 2, 3 and 2 steps.
- R4: Control line k is bit k of `ctl_drv`/`ctl_val`. The drive masks per step are: index 0: 0001, 0100, 0100; index 1: 0000, 1010; index 2: 0111, 0011, 0000; index 3: 1111, 0000 (bit 3 on the left).
- R5: A driven line carries the plan constant, or the pattern bit where the plan marks a pattern position. The pattern positions are index 0 step 1 line 2, index 1 step 1 line 1, index 2 step 0 line 0, and index 3 step 0 line 3. The constant 1s are index 2 step 0 line 2, index 2 step 1 line 1, and index 3 step 0 line 2. Every other value, driven or not, is 0.
- R6: `plan_done` is high for exactly the one cycle after the last step of a plan. During that cycle `ctl_drv` is 0 unless a new plan has been loaded.
- R7: While `test_mode` is 0, all outputs are 0, `load` is ignored, and a running plan is abandoned. Returning to test mode leaves the controller idle until the next load.
- R8: One pattern for module i takes its plan length plus one cycle. Applying 8, 3, 7 and 2 patterns to modules 0 to 3 back to back takes 75 cycles, from the first load cycle to the last done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 selects test operation, 0 normal operation |
| load | input | 1 | Strobe that loads module index and pattern bit and starts a plan |
| pi_mod | input | 2 | Module index from primary inputs |
| pi_pat | input | 1 | Pattern bit from primary inputs |
| ctl_drv | output | 4 | Per-line mask: 1 where the plan takes over the control line |
| ctl_val | output | 4 | Value forced on each control line |
| plan_done | output | 1 | One-cycle pulse after the final plan step |

## Verification
Every plan is run with the pattern bit at 0 and at 1, which separates the pattern positions from the constant ones. Between loads the primary inputs are kept changing, which shows that the registers hold. A reload in the middle of a plan checks the restart. A switch to normal mode in the middle of a plan, with a load issued while in normal mode, shows that the plan is abandoned and the load is not taken. A back-to-back run with the 8/3/7/2 pattern counts checks the per-pattern cycle cost against the 75-cycle total.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned N_MOD   = 4;
  localparam int unsigned N_CTL   = 4;
  localparam int unsigned PAT_W   = 1;
  localparam int unsigned MAX_LEN = 3;
  localparam int unsigned MOD_W   = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int unsigned STEP_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  typedef logic [MOD_W-1:0]  mod_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [N_CTL-1:0]  ctl_t;
  typedef logic [PAT_W-1:0]  pat_t;

  typedef struct packed {
    ctl_t drv;   // lines taken over in this step
    ctl_t ones;  // lines forced to constant 1
    ctl_t pbit;  // lines fed from the pattern register
  } entry_t;

  // index of the final step of each plan
  function automatic step_t plan_last(mod_t m);
    case (m)
      2'd0: plan_last = step_t'(2);
      2'd1: plan_last = step_t'(1);
      2'd2: plan_last = step_t'(2);
      default: plan_last = step_t'(1);
    endcase
  endfunction

  function automatic entry_t plan_entry(mod_t m, step_t s);
    entry_t e;
    e = '0;
    case ({m, s})
      {2'd0, 2'd0}: e.drv = 4'b0001;
      {2'd0, 2'd1}: begin e.drv = 4'b0100; e.pbit = 4'b0100; end
      {2'd0, 2'd2}: e.drv = 4'b0100;
      {2'd1, 2'd1}: begin e.drv = 4'b1010; e.pbit = 4'b0010; end
      {2'd2, 2'd0}: begin e.drv = 4'b0111; e.ones = 4'b0100; e.pbit = 4'b0001; end
      {2'd2, 2'd1}: begin e.drv = 4'b0011; e.ones = 4'b0010; end
      {2'd3, 2'd0}: begin e.drv = 4'b1111; e.ones = 4'b0100; e.pbit = 4'b1000; end
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
  import tpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic load,
  input  mod_t pi_mod,
  input  pat_t pi_pat,
  output mod_t mod_q,
  output pat_t pat_q
);
  logic take;
  assign take = load && test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      pat_q <= '0;
    end else if (take) begin
      mod_q <= pi_mod;
      pat_q <= pi_pat;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && test_mode) |=> ($stable(mod_q) && $stable(pat_q)));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (load && test_mode) |=> (mod_q == $past(pi_mod) && pat_q == $past(pi_pat)));
endmodule

// File: rtl/tpc_sequencer.sv
module tpc_sequencer
  import tpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  test_mode,
  input  logic  load,
  input  step_t last_step,
  output step_t step_q,
  output logic  active_q,
  output logic  done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (!test_mode) begin
      step_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        step_q   <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (step_q == last_step) begin
          step_q   <= '0;
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          step_q <= step_q + step_t'(1);
        end
      end
    end
  end

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !load && active_q && step_q != last_step)
      |=> (active_q && step_q == $past(step_q) + step_t'(1)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !load && active_q && step_q == last_step) |=> (done_q && !active_q));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r7_normal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (!active_q && !done_q));
endmodule

// File: rtl/tpc_decoder.sv
module tpc_decoder
  import tpc_pkg::*;
(
  input  mod_t  mod_q,
  input  step_t step_q,
  input  pat_t  pat_q,
  input  logic  enable,
  output ctl_t  ctl_drv,
  output ctl_t  ctl_val
);
  entry_t cur;
  always_comb cur = plan_entry(mod_q, step_q);

  for (genvar k = 0; k < N_CTL; k++) begin : g_line
    assign ctl_drv[k] = enable & cur.drv[k];
    assign ctl_val[k] = enable & (cur.ones[k] | (cur.pbit[k] & pat_q[0]));
  end
endmodule

// File: rtl/test_plan_ctrl.sv
module test_plan_ctrl
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_mode,
  input  logic       load,
  input  logic [1:0] pi_mod,
  input  logic [0:0] pi_pat,
  output logic [3:0] ctl_drv,
  output logic [3:0] ctl_val,
  output logic       plan_done
);
  mod_t  mod_q;
  pat_t  pat_q;
  step_t step_q;
  step_t last_step;
  logic  active_q;
  logic  done_q;

  tpc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .load(load),
    .pi_mod(pi_mod), .pi_pat(pi_pat), .mod_q(mod_q), .pat_q(pat_q)
  );

  assign last_step = plan_last(mod_q);

  tpc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .load(load),
    .last_step(last_step), .step_q(step_q), .active_q(active_q), .done_q(done_q)
  );

  tpc_decoder u_dec (
    .mod_q(mod_q), .step_q(step_q), .pat_q(pat_q),
    .enable(active_q && test_mode),
    .ctl_drv(ctl_drv), .ctl_val(ctl_val)
  );

  assign plan_done = done_q && test_mode;

  // R5: a value never appears on a line the plan does not take over
  a_r5_val_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_val & ~ctl_drv) == 4'b0000);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_done && !active_q) |-> ctl_drv == 4'b0000);
endmodule

// File: tb/test_plan_ctrl_tb_top.sv
`timescale 1ns/1ps
module test_plan_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic       load = 1'b0;
  logic [1:0] pi_mod = 2'd0;
  logic [0:0] pi_pat = 1'b0;
  logic [3:0] ctl_drv;
  logic [3:0] ctl_val;
  logic       plan_done;

  always #10 clk = ~clk;

  test_plan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .load(load),
    .pi_mod(pi_mod), .pi_pat(pi_pat),
    .ctl_drv(ctl_drv), .ctl_val(ctl_val), .plan_done(plan_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ref_act = 0, ref_step = 0, ref_mod = 0, ref_pat = 0, ref_done = 0;
  int load_edge = 0, done_edge = 0;
  bit finished = 0;

  // plan lengths per module index (R3)
  function automatic int plen(int m);
    case (m) 0: return 3; 1: return 2; 2: return 3; default: return 2; endcase
  endfunction

  // drive masks, bit0 = line 0 (R4)
  function automatic logic [3:0] pdrv(int m, int s);
    if (m == 0) return (s == 0) ? 4'b0001 : 4'b0100;
    if (m == 1) return (s == 1) ? 4'b1010 : 4'b0000;
    if (m == 2) return (s == 0) ? 4'b0111 : (s == 1) ? 4'b0011 : 4'b0000;
    return (s == 0) ? 4'b1111 : 4'b0000;
  endfunction

  // forced values with pattern bit p (R5)
  function automatic logic [3:0] pval(int m, int s, int p);
    logic [3:0] v = 4'b0000;
    if (m == 0 && s == 1) v[2] = p[0];
    if (m == 1 && s == 1) v[1] = p[0];
    if (m == 2 && s == 0) begin v[2] = 1'b1; v[0] = p[0]; end
    if (m == 2 && s == 1) v[1] = 1'b1;
    if (m == 3 && s == 0) begin v[2] = 1'b1; v[3] = p[0]; end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference model, advanced at every edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      ref_act = 0; ref_step = 0; ref_done = 0; ref_mod = 0; ref_pat = 0;
    end else if (!test_mode) begin
      ref_act = 0; ref_step = 0; ref_done = 0;
    end else begin
      ref_done = 0;
      if (load) begin
        ref_mod = pi_mod; ref_pat = pi_pat; ref_act = 1; ref_step = 0;
      end else if (ref_act != 0) begin
        if (ref_step == plen(ref_mod) - 1) begin
          ref_act = 0; ref_step = 0; ref_done = 1;
        end else ref_step++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    logic [3:0] ed, ev;
    logic edone;
    string tag;
    ed = 4'b0000; ev = 4'b0000;
    if (test_mode && ref_act != 0) begin
      ed = pdrv(ref_mod, ref_step);
      ev = pval(ref_mod, ref_step, ref_pat);
    end
    edone = test_mode && (ref_done != 0);
    if (!test_mode) tag = "R7";
    else if (edone) tag = "R6";
    else if (ref_act != 0) tag = "R3 R4 R5";
    else tag = "R1 R2";
    if (!finished) begin
      check(ctl_drv == ed, tag, "ctl_drv", ctl_drv, ed);
      check(ctl_val == ev, tag, "ctl_val", ctl_val, ev);
      check(plan_done == edone, tag, "plan_done", plan_done, edone);
    end
    if (plan_done) done_edge = cyc;
  end

  task automatic cycle(bit ld, int m, int p);
    load = ld; pi_mod = 2'(m); pi_pat = 1'(p);
    if (ld) load_edge = cyc + 1;
    @(negedge clk); #2;
  endtask

  task automatic apply(int m, int p);
    cycle(1, m, p);
    repeat (plen(m)) cycle(0, $urandom_range(3), $urandom_range(1));
  endtask

  initial begin
    int first_edge, expect_len;
    int counts[4] = '{8, 3, 7, 2};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ctl_drv == 0 && ctl_val == 0 && plan_done == 0, "R1", "reset outputs",
          {ctl_drv, ctl_val, 3'b0, plan_done}, 0);
    #2; rst_n = 1'b1;
    @(negedge clk); #2;
    test_mode = 1'b1;
    repeat (2) cycle(0, 3, 1);
    // every plan with both pattern values (R3 R4 R5)
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++) apply(m, p);
    repeat (2) cycle(0, $urandom_range(3), 1);
    // R2: restart in the middle of a plan
    cycle(1, 2, 0);
    cycle(1, 3, 1);
    check(ctl_drv == 4'b1111 && ctl_val == 4'b1100, "R2", "restart step 0",
          {ctl_drv, ctl_val}, 8'hfc);
    repeat (3) cycle(0, 0, 0);
    // R7: abandon a plan, ignore a load in normal mode
    cycle(1, 0, 1);
    test_mode = 1'b0;
    cycle(0, 2, 1);
    cycle(1, 3, 1);
    cycle(0, 1, 0);
    test_mode = 1'b1;
    cycle(0, 1, 0);
    cycle(0, 2, 1);
    check(ctl_drv == 0 && plan_done == 0, "R7", "idle after normal-mode load",
          {ctl_drv, 3'b0, plan_done}, 0);
    // R8: back-to-back run, cost per pattern is length plus one
    expect_len = 0;
    for (int m = 0; m < 4; m++) expect_len += counts[m] * (plen(m) + 1);
    first_edge = -1;
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < counts[m]; n++) begin
        cycle(1, m, n % 2);
        if (first_edge < 0) first_edge = load_edge;
        repeat (plen(m)) cycle(0, $urandom_range(3), $urandom_range(1));
      end
    check(expect_len == 75, "R8", "expected total", expect_len, 75);
    check(done_edge - first_edge + 1 == expect_len, "R8", "total cycles",
          done_edge - first_edge + 1, expect_len);
    repeat (2) cycle(0, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    finished = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule